// File: doc/BRIEF.md
# Security attribution region unit

This block tags every address presented on its lookup port with a security attribute. The attribute is Secure, Non-secure, or Secure and callable from Non-secure code. The attribute comes from a small bank of programmable regions, each set by a base and a limit. Software programs the bank through a 32-bit register port. The port carries a flag that marks each access as Non-secure. The region base and limit registers are reached indirectly: a region-number selector picks which region they touch.

The lookup port is purely combinational. It returns the attribute, a flag that says a single region matched, and that region's number. When the unit is disabled, one control bit decides whether the whole address space is Non-secure or Secure. The `NUM_REGIONS` parameter sets the number of regions.

Top module: `sec_attr_unit`

## Requirements
- R1: Registers are selected by the byte offset `req_addr`: 0x00 control, 0x04 type, 0x08 region number, 0x0C region base, 0x10 region limit. Any other offset reads zero and a write to it changes nothing. `rd_data` is zero in every cycle without a Secure read (`req_valid`=1, `req_write`=0, `req_nonsec`=0).
- R2: An access with `req_nonsec`=1 reads zero, and a write made that way changes no register.
- R3: The control register resets to 0. Bit 0 is the unit enable and bit 1 is the all-Non-secure flag. Bits 31:2 read as zero whatever is written.
- R4: While the enable is 0, the lookup gives `look_ns`=`all-Non-secure flag`, `look_nsc`=0, `look_hit`=0 and `look_region`=0.
- R5: While the enable is 1, an address covered by no enabled region is Secure: `look_ns`=0, `look_nsc`=0, `look_hit`=0.
- R6: The type register reads the region count in bits 7:0, with zeros above. Writes to it have no effect.
- R7: The region number register holds bits 7:0 of the written value. A value at or above `NUM_REGIONS` is not stored. Bits 31:8 read as zero. The register resets to 0.
- R8: The region base register stores bits 31:5 for the selected region. Bits 4:0 read as zero.
- R9: The region limit register stores bits 31:5, bit 1 (callable flag) and bit 0 (region enable) for the selected region. Bits 4:2 read as zero. Every region resets to all zero, so every region starts disabled.
- R10: An address matches an enabled region when base <= address <= {limit[31:5], 5'h1F}, compared unsigned. Both ends are inclusive.
- R11: When exactly one enabled region matches and the unit is enabled, `look_hit`=1 and `look_region` gives that region's index. A region with its callable flag at 0 gives `look_ns`=1, `look_nsc`=0. With the flag at 1 it gives `look_ns`=0, `look_nsc`=1. `look_ns` and `look_nsc` are never both 1.
- R12: When two or more enabled regions match, the result is Secure with `look_nsc`=0, `look_hit`=0 and `look_region`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_nonsec | input | 1 | Access is made from Non-secure state |
| req_addr | input | 5 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational |
| look_addr | input | 32 | Address to classify |
| look_ns | output | 1 | Address is Non-secure |
| look_nsc | output | 1 | Address is Secure and Non-secure callable |
| look_hit | output | 1 | Exactly one enabled region matched |
| look_region | output | 8 | Index of the matching region |

## Verification
Read data and every lookup output are combinational. They are due in the same cycle that the request or address is presented. A register write takes effect at the next rising edge, so it first shows on a read or a lookup in the following cycle. The bench drives inputs on the falling edge and compares shortly after. It compares against a behavioural model whose state it updates only after the rising edge that commits the write. This means each comparison uses exactly the state the design holds in that cycle.

// File: rtl/sec_attr_unit.sv
module sec_attr_unit #(
  parameter int NUM_REGIONS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_nonsec,
  input  logic [4:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] rd_data,
  input  logic [31:0] look_addr,
  output logic        look_ns,
  output logic        look_nsc,
  output logic        look_hit,
  output logic [7:0]  look_region
);
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam logic [4:0] OFF_CTRL = 5'h00;
  localparam logic [4:0] OFF_TYPE = 5'h04;
  localparam logic [4:0] OFF_SEL  = 5'h08;
  localparam logic [4:0] OFF_BASE = 5'h0C;
  localparam logic [4:0] OFF_LIM  = 5'h10;

  logic ctrl_en, ctrl_allns;
  logic [7:0] sel;
  logic [NUM_REGIONS-1:0][26:0] base_q, lim_q;
  logic [NUM_REGIONS-1:0] nsc_q, ren_q, hit_vec;
  logic [IDX_W-1:0] sel_idx;
  logic sel_valid, wr_ok, rd_ok, one_hit, nsc_sel;
  logic [7:0] hit_idx;

  assign wr_ok     = req_valid & req_write & ~req_nonsec;
  assign rd_ok     = req_valid & ~req_write & ~req_nonsec;
  assign sel_valid = {24'b0, sel} < 32'(NUM_REGIONS);
  assign sel_idx   = sel[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en    <= 1'b0;
      ctrl_allns <= 1'b0;
      sel        <= '0;
      base_q     <= '0;
      lim_q      <= '0;
      nsc_q      <= '0;
      ren_q      <= '0;
    end else if (wr_ok) begin
      case (req_addr)
        OFF_CTRL: begin
          ctrl_en    <= req_wdata[0];
          ctrl_allns <= req_wdata[1];
        end
        OFF_SEL:
          if ({24'b0, req_wdata[7:0]} < 32'(NUM_REGIONS)) sel <= req_wdata[7:0];
        OFF_BASE:
          if (sel_valid) base_q[sel_idx] <= req_wdata[31:5];
        OFF_LIM:
          if (sel_valid) begin
            lim_q[sel_idx] <= req_wdata[31:5];
            nsc_q[sel_idx] <= req_wdata[1];
            ren_q[sel_idx] <= req_wdata[0];
          end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_ok) begin
      case (req_addr)
        OFF_CTRL: rd_data = {30'b0, ctrl_allns, ctrl_en};
        OFF_TYPE: rd_data = {24'b0, 8'(NUM_REGIONS)};
        OFF_SEL:  rd_data = {24'b0, sel};
        OFF_BASE: if (sel_valid) rd_data = {base_q[sel_idx], 5'b0};
        OFF_LIM:  if (sel_valid) rd_data = {lim_q[sel_idx], 3'b0, nsc_q[sel_idx], ren_q[sel_idx]};
        default:  rd_data = '0;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    assign hit_vec[g] = ren_q[g] && (look_addr[31:5] >= base_q[g]) && (look_addr[31:5] <= lim_q[g]);
  end

  assign one_hit = $onehot(hit_vec);

  always_comb begin
    hit_idx = '0;
    nsc_sel = 1'b0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit_vec[i]) begin
        hit_idx = 8'(i);
        nsc_sel = nsc_q[i];
      end
    end
  end

  assign look_hit    = ctrl_en & one_hit;
  assign look_nsc    = look_hit & nsc_sel;
  assign look_ns     = ctrl_en ? (look_hit & ~nsc_sel) : ctrl_allns;
  assign look_region = look_hit ? hit_idx : 8'd0;
endmodule

// File: rtl/sec_attr_unit_chk.sv
module sec_attr_unit_chk #(
  parameter int NUM_REGIONS = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic        req_nonsec,
  input logic [4:0]  req_addr,
  input logic [31:0] req_wdata,
  input logic [31:0] rd_data,
  input logic        look_ns,
  input logic        look_nsc,
  input logic        look_hit,
  input logic [7:0]  look_region,
  input logic        ctrl_en,
  input logic        ctrl_allns,
  input logic [7:0]  sel
);
  assert_ns_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_nonsec) |-> rd_data == 32'd0);

  assert_ns_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_nonsec) |=> ($stable(ctrl_en) && $stable(ctrl_allns) && $stable(sel)));

  assert_ctrl_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 5'h00) |-> rd_data[31:2] == 30'd0);

  assert_disabled_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> (look_ns == ctrl_allns && !look_nsc && !look_hit));

  assert_miss_secure_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && !look_hit) |-> (!look_ns && !look_nsc && look_region == 8'd0));

  assert_sel_filter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 5'h08 && {24'b0, req_wdata[7:0]} >= 32'(NUM_REGIONS)) |=> $stable(sel));

  assert_sel_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    {24'b0, sel} < 32'(NUM_REGIONS));

  assert_attr_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(look_ns && look_nsc));

  assert_hit_region_R11: assert property (@(posedge clk) disable iff (!rst_n)
    look_hit |-> ({24'b0, look_region} < 32'(NUM_REGIONS) && look_ns != look_nsc));
endmodule

bind sec_attr_unit sec_attr_unit_chk #(.NUM_REGIONS(NUM_REGIONS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_nonsec(req_nonsec), .req_addr(req_addr), .req_wdata(req_wdata),
  .rd_data(rd_data), .look_ns(look_ns), .look_nsc(look_nsc),
  .look_hit(look_hit), .look_region(look_region), .ctrl_en(ctrl_en),
  .ctrl_allns(ctrl_allns), .sel(sel)
);

// File: tb/sec_attr_unit_test.sv
`timescale 1ns/1ps
module sec_attr_unit_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_nonsec = 1'b0;
  logic [4:0] req_addr = '0;
  logic [31:0] req_wdata = '0, look_addr = '0;
  logic [31:0] rd_data;
  logic look_ns, look_nsc, look_hit;
  logic [7:0] look_region;

  always #2.5 clk = ~clk;

  sec_attr_unit #(.NUM_REGIONS(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_nonsec(req_nonsec), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .look_addr(look_addr), .look_ns(look_ns),
    .look_nsc(look_nsc), .look_hit(look_hit), .look_region(look_region)
  );

  int checks = 0, errors = 0;
  string cur = "R3";

  bit m_en, m_allns;
  int m_sel;
  logic [31:0] m_base [N];
  logic [31:0] m_lim [N];

  function automatic logic [31:0] model_read(input logic [4:0] a);
    case (a)
      5'h00: return {30'b0, m_allns, m_en};
      5'h04: return 32'(N);
      5'h08: return 32'(m_sel);
      5'h0C: return m_base[m_sel];
      5'h10: return m_lim[m_sel];
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [10:0] model_look(input logic [31:0] a);
    int cnt = 0, idx = 0;
    if (!m_en) return {m_allns, 1'b0, 1'b0, 8'd0};
    for (int i = 0; i < N; i++)
      if (m_lim[i][0] && a >= {m_base[i][31:5], 5'b0} && a <= {m_lim[i][31:5], 5'h1F}) begin
        cnt++;
        idx = i;
      end
    if (cnt != 1) return 11'd0;
    return {~m_lim[idx][1], m_lim[idx][1], 1'b1, 8'(idx)};
  endfunction

  task automatic cycle(input bit v, input bit w, input bit ns, input logic [4:0] a,
                       input logic [31:0] d, input logic [31:0] la);
    logic [31:0] exp_rd;
    logic [10:0] exp_lk;
    @(negedge clk);
    req_valid = v; req_write = w; req_nonsec = ns; req_addr = a; req_wdata = d; look_addr = la;
    #1;
    exp_rd = (v && !w && !ns) ? model_read(a) : 32'd0;
    exp_lk = model_look(la);
    checks++;
    if (rd_data !== exp_rd) begin
      errors++;
      $display("FAIL %s rd_data off=%h actual=%h expected=%h", cur, a, rd_data, exp_rd);
    end
    checks++;
    if ({look_ns, look_nsc, look_hit, look_region} !== exp_lk) begin
      errors++;
      $display("FAIL %s lookup addr=%h actual=%h expected=%h", cur, la,
               {look_ns, look_nsc, look_hit, look_region}, exp_lk);
    end
    @(posedge clk);
    if (v && w && !ns) begin
      case (a)
        5'h00: begin m_en = d[0]; m_allns = d[1]; end
        5'h08: if (int'(d[7:0]) < N) m_sel = int'(d[7:0]);
        5'h0C: m_base[m_sel] = d & 32'hFFFF_FFE0;
        5'h10: m_lim[m_sel] = d & 32'hFFFF_FFE3;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cycle(1, 1, 0, a, d, look_addr);
  endtask
  task automatic rd(input logic [4:0] a);
    cycle(1, 0, 0, a, 0, look_addr);
  endtask
  task automatic lk(input logic [31:0] la);
    cycle(0, 0, 0, 0, 0, la);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_en = 0; m_allns = 0; m_sel = 0;
    for (int i = 0; i < N; i++) begin m_base[i] = 0; m_lim[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    cur = "R3"; rd(5'h00);
    cur = "R6"; rd(5'h04); wr(5'h04, 32'hFFFF_FFFF); rd(5'h04);
    cur = "R7"; rd(5'h08);
    cur = "R9"; rd(5'h10); rd(5'h0C);
    cur = "R4"; lk(32'h1234_5678);
    cur = "R3"; wr(5'h00, 32'hFFFF_FFFE); rd(5'h00);
    cur = "R4"; lk(32'h0000_0000); lk(32'hFFFF_FFFF);
    cur = "R2"; cycle(1, 1, 1, 5'h00, 32'h1, 32'h0);
    rd(5'h00); cycle(1, 0, 1, 5'h04, 0, 32'h0); cycle(1, 0, 1, 5'h00, 0, 32'h0);
    cycle(1, 1, 1, 5'h08, 32'h2, 32'h0); rd(5'h08);
    cur = "R3"; wr(5'h00, 32'h0); lk(32'h0040_0000);

    cur = "R8"; wr(5'h08, 0); wr(5'h0C, 32'h0020_001F); rd(5'h0C);
    cur = "R9"; wr(5'h10, 32'h003F_FFFF); rd(5'h10);
    wr(5'h08, 1); wr(5'h0C, 32'h2020_0000); wr(5'h10, 32'h203F_FFE1); rd(5'h10);
    cur = "R2"; cycle(1, 1, 1, 5'h10, 32'h0, 32'h0); rd(5'h10);

    cur = "R11"; wr(5'h00, 32'h1);
    lk(32'h0020_0000); lk(32'h2030_0000);
    cur = "R10"; lk(32'h003F_FFFF); lk(32'h001F_FFFF); lk(32'h203F_FFFF); lk(32'h2020_0000);
    cur = "R5"; lk(32'h0040_0000); lk(32'h1000_0000); lk(32'h2040_0000);

    cur = "R7"; wr(5'h08, 32'd8); rd(5'h08); wr(5'h08, 32'hFF); rd(5'h08);
    wr(5'h08, 32'h0000_0103); rd(5'h08);

    cur = "R12"; wr(5'h08, 2); wr(5'h0C, 32'h2030_0000); wr(5'h10, 32'h204F_FFE1);
    lk(32'h2035_0000); lk(32'h203F_FFFF); lk(32'h2045_0000); lk(32'h2025_0000);

    cur = "R1"; rd(5'h14); wr(5'h14, 32'hFFFF_FFFF); rd(5'h00); rd(5'h1C); rd(5'h02);
    cycle(1, 1, 0, 5'h01, 32'h0, 32'h2025_0000);
    cur = "R9"; wr(5'h08, 0); wr(5'h10, 32'h003F_FFE2); lk(32'h0030_0000);

    cur = "R10";
    for (int k = 0; k < 40; k++) lk(32'h001F_FFF0 + 32'(k) * 32'h0001_0000);
    for (int k = 0; k < 16; k++) lk(32'h201F_FFF8 + 32'(k) * 32'h0004_0000);

    cur = "R4"; wr(5'h00, 32'h2); lk(32'h2030_0000); wr(5'h00, 32'h0); lk(32'h2030_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule